// File: doc/BRIEF.md
# Burst-Mode Manchester Event Serializer

This block takes fixed-width address events from a parallel valid/ready source and sends each one as a self-contained serial burst on a single data line. The block runs on a clock at twice the bit rate, so each Manchester half-bit lasts one clock cycle.

Each burst starts with a two-bit alignment preamble, followed by the event word. All of these bits are Manchester coded, so the far end can recover timing from the transitions alone. The data line is parked low between events, and nothing is sent while no event is pending.

A new event starts its burst on the cycle after it is taken, however long the line has been quiet. A four-phase request/acknowledge pair paces events against the receiver. The block raises its request together with the burst. It takes no further event until the burst is over, the request has been dropped in answer to the acknowledge, and the acknowledge has gone low again.

Top module: `manch_burst_tx`

## Requirements
- R1: `ev_ready` is high only while the block is idle. An event is taken at a rising clock edge where `ev_valid` and `ev_ready` are both high. `ev_valid` has no effect at any other edge.
- R2: The burst begins in the cycle right after the capture edge. It lasts exactly 2*(EVENT_W+2) cycles, which is 68 with the default width.
- R3: Each bit occupies two consecutive cycles. A 0 is sent as high then low, and a 1 is sent as low then high, so the line always changes level between the two halves of a bit.
- R4: The serial bit order is preamble bit 1, then preamble bit 0, then the event word starting at bit EVENT_W-1 and ending at bit 0.
- R5: `line_out` is low in every cycle that is not part of a burst.
- R6: `req_out` rises in the first cycle of a burst and stays high until `ack_in` is sampled high at a clock edge. It is low in the cycle after that edge.
- R7: After a burst, `ev_ready` stays low until the burst has finished, `req_out` is low, and `ack_in` has been sampled low.
- R8: A burst needs no training sequence. After an idle gap of any length, the first active cycle is the first preamble half-bit.
- R9: While `rst_n` is low, and right after it is released, `line_out` and `req_out` are low and `ev_ready` is high. Asserting reset in the middle of a burst drops the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_data | input | EVENT_W | Event word to send |
| ev_valid | input | 1 | Source has an event on `ev_data` |
| ev_ready | output | 1 | Block is idle and will take an event |
| line_out | output | 1 | Manchester-coded serial data |
| req_out | output | 1 | Request to the far end, four-phase |
| ack_in | input | 1 | Acknowledge from the far end |

## Verification
The assertions check on every cycle that the line is low while the block is idle, and that a taken event closes the input. They also check that the request rises only after a capture and falls the cycle after an acknowledge, that each bit has its mid-bit transition, and that the input reopens only after the request is low and the acknowledge has been seen low. The preamble value, the most-significant-first order of the data bits, the exact burst length, and the different orderings of acknowledge against the end of the burst can only be shown by the bench scenarios. In those scenarios, a reference model predicts every half-bit, the request and the ready level on every cycle. The runs cover early acknowledges, late acknowledges, long idle gaps, an event held waiting while the block is busy, and a reset in the middle of a burst.

// File: rtl/manch_burst_tx.sv
module manch_burst_tx #(
  parameter int EVENT_W = 32,
  parameter int PRE_W = 2,
  parameter logic [PRE_W-1:0] PRE_BITS = 2'b10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVENT_W-1:0] ev_data,
  input  logic               ev_valid,
  output logic               ev_ready,
  output logic               line_out,
  output logic               req_out,
  input  logic               ack_in
);

  localparam int FRAME_W = EVENT_W + PRE_W;
  localparam int CW = $clog2(FRAME_W);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_DRAIN} st_t;

  st_t                st;
  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      bit_cnt;
  logic               half_q;
  logic               req_q;
  logic               take;
  logic               last;
  logic               sending;
  logic               cur;

  assign ev_ready = (st == S_IDLE);
  assign take     = ev_valid && ev_ready;
  assign sending  = (st == S_SEND);
  assign last     = half_q && (bit_cnt == CW'(FRAME_W - 1));
  assign cur      = sh[FRAME_W-1];
  assign line_out = sending && (half_q ? cur : ~cur);
  assign req_out  = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sh      <= '0;
      bit_cnt <= '0;
      half_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          sh      <= {PRE_BITS, ev_data};
          bit_cnt <= '0;
          half_q  <= 1'b0;
          st      <= S_SEND;
        end
        S_SEND: begin
          half_q <= ~half_q;
          if (half_q) begin
            sh      <= sh << 1;
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (last) st <= S_DRAIN;
        end
        S_DRAIN: if (!req_q && !ack_in) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (take)   req_q <= 1'b1;
    else if (ack_in) req_q <= 1'b0;
  end

endmodule

module manch_burst_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_valid,
  input logic ev_ready,
  input logic line_out,
  input logic req_out,
  input logic ack_in,
  input logic sending,
  input logic half_q
);

  // R5
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |-> !line_out);

  // R1
  take_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> !ev_ready);

  // R6
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_out) |-> $past(ev_valid && ev_ready));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out && ack_in) |=> !req_out);

  // R3
  mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && half_q) |-> (line_out != $past(line_out)));

  // R7
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_ready) |-> $past(!req_out && !ack_in));

endmodule

bind manch_burst_tx manch_burst_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .line_out(line_out), .req_out(req_out), .ack_in(ack_in),
  .sending(sending), .half_q(half_q)
);

// File: tb/test_manch_burst_tx.sv
module test_manch_burst_tx;
  localparam int CLK_P = 10;
  localparam int EW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [EW-1:0] ev_data = '0;
  logic          ev_valid = 1'b0;
  logic          ev_ready, line_out, req_out;
  logic          ack_in = 1'b0;

  int total = 0, bad = 0, cyc = 0;
  int ack_dly = 3, rel_dly = 0, ack_cnt = 0;
  int sent = 0, bursts = 0;
  bit done = 0;

  bit mq[$];
  int m_st = 0;
  bit m_req = 0;

  always #(CLK_P/2) clk = ~clk;

  manch_burst_tx i_manch_burst_tx (
    .clk(clk), .rst_n(rst_n), .ev_data(ev_data), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .line_out(line_out), .req_out(req_out), .ack_in(ack_in)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", rq, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_st = 0; m_req = 0;
    end else begin
      int ns;
      bit nr;
      logic [EW+1:0] fr;
      ns = m_st; nr = m_req;
      case (m_st)
        0: if (ev_valid) begin
          fr = {2'b10, ev_data};
          for (int i = EW + 1; i >= 0; i--) begin
            mq.push_back(~fr[i]);
            mq.push_back(fr[i]);
          end
          ns = 1; nr = 1; bursts++;
        end
        1: begin
          void'(mq.pop_front());
          if (mq.size() == 0) ns = 2;
        end
        default: if (!m_req && !ack_in) ns = 0;
      endcase
      if (!(m_st == 0 && ev_valid) && ack_in) nr = 0;
      m_st = ns; m_req = nr;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit el;
      el = (m_st == 1) ? mq[0] : 1'b0;
      chk(line_out == el, (m_st == 1) ? "R3/R4 half-bit" : "R5 parked line", line_out, el);
      chk(req_out == m_req, "R6 request", req_out, m_req);
      chk(ev_ready == (m_st == 0), "R1/R7 ready", ev_ready, m_st == 0);
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_in <= 1'b0; ack_cnt <= 0;
    end else if (!ack_in && req_out) begin
      if (ack_cnt >= ack_dly) begin ack_in <= 1'b1; ack_cnt <= 0; end
      else ack_cnt <= ack_cnt + 1;
    end else if (ack_in && !req_out) begin
      if (ack_cnt >= rel_dly) begin ack_in <= 1'b0; ack_cnt <= 0; end
      else ack_cnt <= ack_cnt + 1;
    end
  end

  task automatic send(input logic [EW-1:0] d);
    bit was;
    @(negedge clk);
    ev_valid = 1'b1; ev_data = d;
    forever begin
      was = ev_ready;
      @(negedge clk);
      if (was) break;
    end
    ev_valid = 1'b0; ev_data = '0;
    sent++;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle;
    int g = 0;
    while (!ev_ready && g < 2000) begin @(negedge clk); g++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 state held in reset
    chk(line_out == 0, "R9 line in reset", line_out, 0);
    chk(req_out == 0, "R9 req in reset", req_out, 0);
    chk(ev_ready == 1, "R9 ready in reset", ev_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ev_ready == 1 && line_out == 0, "R9 after release", {ev_ready, line_out}, 2);

    // R3 R4 ack arrives during the burst
    ack_dly = 3; rel_dly = 0;
    send(32'hA5C3_0F96);
    send(32'h0000_0000);
    send(32'hFFFF_FFFF);
    wait_idle();
    // R7 ack held long after the burst ends
    ack_dly = 90; rel_dly = 12;
    send(32'h8000_0001);
    send(32'h1234_5678);
    wait_idle();
    // R8 long quiet gap, then immediate burst
    ack_dly = 0; rel_dly = 4;
    gap(300);
    chk(line_out == 0, "R5 line after gap", line_out, 0);
    send(32'hDEAD_BEEF);
    // R1 event held waiting while the block is busy
    send(32'h5555_AAAA);
    wait_idle();
    // R9 reset in mid-burst
    ack_dly = 5; rel_dly = 1;
    fork send(32'hCAFE_F00D); join_none
    gap(20);
    rst_n = 1'b0;
    @(negedge clk);
    chk(line_out == 0 && req_out == 0, "R9 mid-burst reset", {line_out, req_out}, 0);
    chk(ev_ready == 1, "R9 ready on reset", ev_ready, 1);
    gap(2);
    rst_n = 1'b1;
    gap(3);
    chk(line_out == 0 && req_out == 0, "R9 burst dropped", {line_out, req_out}, 0);
    send(32'h0F0F_F0F0);
    wait_idle();
    gap(5);
    // R2 one burst per accepted event
    chk(bursts == sent, "R2 burst count", bursts, sent);
    done = 1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog cyc=%0d actual=0 expected=1", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule